// File: doc/BRIEF.md
# Byte/Word Host Bus Interface with Automatic Power Save

This block connects an asynchronous, SRAM-style host bus to a 16-bit internal array port. The host drives active-low chip-select, output-enable and write-enable strobes, an address bus, write data and a width-select input. All of these pass through a two-stage synchronizer into the block clock domain. The block then turns host reads and writes into single-cycle requests on the array port. It steers the two byte lanes for 8-bit or 16-bit access and produces one output-enable per lane for the pad drivers.

In 16-bit mode (width-select high), address bit 0 is a don't-care. Bits above it form the word address, and both lanes carry data. In 8-bit mode (width-select low), address bit 0 picks the low or high half of the addressed word. That byte is returned on the low lane, and the high lane is never driven. A byte write fills only the chosen half of the word and marks it with a byte-enable bit.

An automatic power-save detector raises a flag once a read has returned data. While that flag is set, the block keeps presenting the held data and makes no further array access. The flag clears only when the access key changes (word address, width mode, or address bit 0 in 8-bit mode) or when a write commits. A standby flag follows chip-select, but it stays low while the storage engine reports an operation in progress, so that operation can finish.

Top module: `hbi_bus_if`

## Requirements
- R1: In 8-bit mode (host_byte_n = 0), a read returns the low half of the word when host_addr[0] = 0 and the high half when host_addr[0] = 1. The byte appears on host_rdata[7:0], and host_rdata[15:8] is 0.
- R2: In 8-bit mode, lane_hi_oe is never asserted.
- R3: In 16-bit mode (host_byte_n = 1), host_addr[0] is ignored and arr_addr = host_addr[ADDR_W-1:1]. All 16 bits of the word appear on host_rdata, and a read request carries arr_be = 2'b11.
- R4: lane_lo_oe is asserted only while host_ce_n = 0, host_oe_n = 0 and host_we_n = 1. lane_hi_oe additionally requires 16-bit mode.
- R5: standby is 1 when host_ce_n is high and eng_busy is low. While eng_busy is high, standby stays 0 regardless of chip-select.
- R6: Once read data returns, pwr_save is 1. While the access key is unchanged, no further array read request is made, even if output-enable is toggled.
- R7: A change of the word address, or of host_addr[0] in 8-bit mode, clears pwr_save without issuing an array request while output-enable is high.
- R8: A change of host_byte_n while selected counts as a new access and clears pwr_save.
- R9: A byte write uses arr_be = 2'b01 with data in arr_wdata[7:0] when host_addr[0] = 0, or arr_be = 2'b10 with data in arr_wdata[15:8] when host_addr[0] = 1. The other half is 0, and host_wdata[15:8] is ignored. A 16-bit write uses arr_be = 2'b11 with all of host_wdata.
- R10: A write commits on the rising edge of host_we_n while selected. The commit issues exactly one array request with arr_we = 1 and clears pwr_save, so the next read fetches again.
- R11: During and after reset, arr_req, pwr_save, lane_lo_oe and lane_hi_oe are 0 and standby is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_ce_n | input | 1 | Host chip-select, active low |
| host_oe_n | input | 1 | Host output-enable, active low |
| host_we_n | input | 1 | Host write strobe, active low |
| host_byte_n | input | 1 | Width select: 0 = 8-bit, 1 = 16-bit |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data toward the pad drivers |
| lane_lo_oe | output | 1 | Output enable for lane bits 7:0 |
| lane_hi_oe | output | 1 | Output enable for lane bits 15:8 |
| arr_req | output | 1 | Single-cycle array request |
| arr_we | output | 1 | Request is a write |
| arr_addr | output | ADDR_W-1 | Array word address |
| arr_wdata | output | 16 | Array write data |
| arr_be | output | 2 | Array byte enables |
| arr_rvalid | input | 1 | Array read data valid |
| arr_rdata | input | 16 | Array read data |
| eng_busy | input | 1 | Storage engine operation in progress |
| standby | output | 1 | Standby flag |
| pwr_save | output | 1 | Automatic power-save flag |

## Verification
The hardest case to reach from the ports is a cleared power-save flag with no new array access. Normally any key change made while reading starts a new fetch at once, and that fetch sets the flag again. The stimulus therefore raises output-enable while keeping chip-select low, and only then changes the address or width mode. It then checks that the flag has dropped and that the array request count has not moved. A write to the address that was just read is used in the same way: it shows that a commit drops the flag and forces a fresh fetch that returns the newly written word.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

    localparam int LANE_W = 8;
    localparam int DATA_W = 2 * LANE_W;
    localparam int BE_W   = DATA_W / LANE_W;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic byte_n;
    } hbi_ctl_t;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_WAIT = 1'b1
    } rd_state_e;

    // Place the held word on the host lanes for the given width mode.
    function automatic logic [DATA_W-1:0] lane_steer(
        input logic [DATA_W-1:0] word,
        input logic              byte_n,
        input logic              a0
    );
        logic [LANE_W-1:0] sel;
        sel = a0 ? word[DATA_W-1:LANE_W] : word[LANE_W-1:0];
        return byte_n ? word : {{LANE_W{1'b0}}, sel};
    endfunction

    // Position host write data inside the array word.
    function automatic logic [DATA_W-1:0] wr_place(
        input logic [DATA_W-1:0] d,
        input logic              byte_n,
        input logic              a0
    );
        if (byte_n)
            return d;
        return a0 ? {d[LANE_W-1:0], {LANE_W{1'b0}}}
                  : {{LANE_W{1'b0}}, d[LANE_W-1:0]};
    endfunction

    function automatic logic [BE_W-1:0] byte_en(
        input logic byte_n,
        input logic a0
    );
        if (byte_n)
            return '1;
        return a0 ? 2'b10 : 2'b01;
    endfunction

endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/hbi_write_fmt.sv
module hbi_write_fmt
    import hbi_pkg::*;
#(
    parameter int ADDR_W = 24,
    localparam int WORD_AW = ADDR_W - 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cur_ce_n,
    input  logic               cur_we_n,
    input  logic               cur_byte_n,
    input  logic [ADDR_W-1:0]  cur_addr,
    input  logic [DATA_W-1:0]  cur_data,
    output logic               wr_commit,
    output logic [WORD_AW-1:0] wr_addr,
    output logic [DATA_W-1:0]  wr_data,
    output logic [BE_W-1:0]    wr_be
);
    logic               prv_ce_n;
    logic               prv_we_n;
    logic               prv_byte_n;
    logic [ADDR_W-1:0]  prv_addr;
    logic [DATA_W-1:0]  prv_data;

    // One more stage holds the values seen while the strobe was low.
    always_ff @(posedge clk) begin
        if (rst) begin
            prv_ce_n   <= 1'b1;
            prv_we_n   <= 1'b1;
            prv_byte_n <= 1'b1;
            prv_addr   <= '0;
            prv_data   <= '0;
        end else begin
            prv_ce_n   <= cur_ce_n;
            prv_we_n   <= cur_we_n;
            prv_byte_n <= cur_byte_n;
            prv_addr   <= cur_addr;
            prv_data   <= cur_data;
        end
    end

    assign wr_commit = !prv_we_n && cur_we_n && !prv_ce_n && !cur_ce_n;
    assign wr_addr   = prv_addr[ADDR_W-1:1];
    assign wr_data   = wr_place(prv_data, prv_byte_n, prv_addr[0]);
    assign wr_be     = byte_en(prv_byte_n, prv_addr[0]);
endmodule

// File: rtl/hbi_read_ctl.sv
module hbi_read_ctl
    import hbi_pkg::*;
#(
    parameter int ADDR_W = 24,
    localparam int WORD_AW = ADDR_W - 1,
    localparam int KEY_W   = ADDR_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  hbi_ctl_t           cur_ctl,
    input  logic [ADDR_W-1:0]  cur_addr,
    input  logic               wr_commit,
    input  logic               arr_rvalid,
    input  logic [DATA_W-1:0]  arr_rdata,
    output logic               rd_issue,
    output logic [WORD_AW-1:0] rd_addr,
    output logic [DATA_W-1:0]  rd_word,
    output logic               rd_byte_n,
    output logic               rd_a0,
    output logic               pwr_save
);
    rd_state_e        state;
    logic             have;
    logic [KEY_W-1:0] have_key;
    logic [KEY_W-1:0] req_key;
    logic [KEY_W-1:0] key_cur;
    logic             rd_cond;
    logic             key_diff;

    // Key layout: {width mode, word address, byte select (0 in 16-bit mode)}
    assign key_cur  = {cur_ctl.byte_n, cur_addr[ADDR_W-1:1],
                       cur_ctl.byte_n ? 1'b0 : cur_addr[0]};
    assign key_diff = (key_cur != have_key);
    assign rd_cond  = !cur_ctl.ce_n && !cur_ctl.oe_n && cur_ctl.we_n;
    assign rd_issue = (state == RD_IDLE) && rd_cond && !wr_commit
                      && (!have || key_diff);
    assign rd_addr  = key_cur[ADDR_W-1:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RD_IDLE;
            have     <= 1'b0;
            have_key <= '0;
            req_key  <= '0;
            rd_word  <= '0;
            pwr_save <= 1'b0;
        end else begin
            case (state)
                RD_IDLE: begin
                    if (key_diff)
                        pwr_save <= 1'b0;
                    if (rd_issue) begin
                        state   <= RD_WAIT;
                        req_key <= key_cur;
                    end
                end
                RD_WAIT: begin
                    if (arr_rvalid) begin
                        state    <= RD_IDLE;
                        rd_word  <= arr_rdata;
                        have     <= 1'b1;
                        have_key <= req_key;
                        pwr_save <= 1'b1;
                    end
                end
                default: state <= RD_IDLE;
            endcase
            if (wr_commit) begin
                have     <= 1'b0;
                pwr_save <= 1'b0;
            end
        end
    end

    assign rd_byte_n = have_key[KEY_W-1];
    assign rd_a0     = have_key[0];
endmodule

// File: rtl/hbi_bus_if.sv
module hbi_bus_if
    import hbi_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_ce_n,
    input  logic                host_oe_n,
    input  logic                host_we_n,
    input  logic                host_byte_n,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [15:0]         host_wdata,
    output logic [15:0]         host_rdata,
    output logic                lane_lo_oe,
    output logic                lane_hi_oe,
    output logic                arr_req,
    output logic                arr_we,
    output logic [ADDR_W-2:0]   arr_addr,
    output logic [15:0]         arr_wdata,
    output logic [1:0]          arr_be,
    input  logic                arr_rvalid,
    input  logic [15:0]         arr_rdata,
    input  logic                eng_busy,
    output logic                standby,
    output logic                pwr_save
);
    localparam int WORD_AW = ADDR_W - 1;
    localparam int CTL_W   = $bits(hbi_ctl_t);
    localparam int SYNC_W  = CTL_W + ADDR_W + DATA_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = {{CTL_W{1'b1}}, {(ADDR_W + DATA_W){1'b0}}};

    hbi_ctl_t            cur_ctl;
    logic [ADDR_W-1:0]   cur_addr;
    logic [DATA_W-1:0]   cur_data;
    logic                wr_commit;
    logic [WORD_AW-1:0]  wr_addr;
    logic [DATA_W-1:0]   wr_data;
    logic [BE_W-1:0]     wr_be;
    logic                rd_issue;
    logic [WORD_AW-1:0]  rd_addr;
    logic [DATA_W-1:0]   rd_word;
    logic                rd_byte_n;
    logic                rd_a0;
    logic                rd_lane_ok;

    hbi_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   ({host_ce_n, host_oe_n, host_we_n, host_byte_n, host_addr, host_wdata}),
        .q   ({cur_ctl, cur_addr, cur_data})
    );

    hbi_write_fmt #(.ADDR_W(ADDR_W)) i_wr (
        .clk        (clk),
        .rst        (rst),
        .cur_ce_n   (cur_ctl.ce_n),
        .cur_we_n   (cur_ctl.we_n),
        .cur_byte_n (cur_ctl.byte_n),
        .cur_addr   (cur_addr),
        .cur_data   (cur_data),
        .wr_commit  (wr_commit),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_be      (wr_be)
    );

    hbi_read_ctl #(.ADDR_W(ADDR_W)) i_rd (
        .clk        (clk),
        .rst        (rst),
        .cur_ctl    (cur_ctl),
        .cur_addr   (cur_addr),
        .wr_commit  (wr_commit),
        .arr_rvalid (arr_rvalid),
        .arr_rdata  (arr_rdata),
        .rd_issue   (rd_issue),
        .rd_addr    (rd_addr),
        .rd_word    (rd_word),
        .rd_byte_n  (rd_byte_n),
        .rd_a0      (rd_a0),
        .pwr_save   (pwr_save)
    );

    assign rd_lane_ok = !cur_ctl.ce_n && !cur_ctl.oe_n && cur_ctl.we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            arr_req    <= 1'b0;
            arr_we     <= 1'b0;
            arr_addr   <= '0;
            arr_wdata  <= '0;
            arr_be     <= '1;
            lane_lo_oe <= 1'b0;
            lane_hi_oe <= 1'b0;
            standby    <= 1'b1;
        end else begin
            arr_req    <= wr_commit || rd_issue;
            arr_we     <= wr_commit;
            arr_addr   <= wr_commit ? wr_addr : rd_addr;
            arr_wdata  <= wr_commit ? wr_data : '0;
            arr_be     <= wr_commit ? wr_be : '1;
            lane_lo_oe <= rd_lane_ok;
            lane_hi_oe <= rd_lane_ok && cur_ctl.byte_n;
            standby    <= cur_ctl.ce_n && !eng_busy;
        end
    end

    assign host_rdata = lane_steer(rd_word, rd_byte_n, rd_a0);
endmodule

// File: rtl/hbi_bus_if_chk.sv
module hbi_bus_if_chk
    import hbi_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input hbi_ctl_t    cur_ctl,
    input logic        eng_busy,
    input logic        lane_lo_oe,
    input logic        lane_hi_oe,
    input logic        arr_req,
    input logic        arr_we,
    input logic [1:0]  arr_be,
    input logic [15:0] arr_wdata,
    input logic        standby,
    input logic        pwr_save
);
    p_hi_lane_word_only_r2: assert property (@(posedge clk) disable iff (rst)
        lane_hi_oe |-> $past(cur_ctl.byte_n));

    p_lane_select_r4: assert property (@(posedge clk) disable iff (rst)
        lane_lo_oe |-> $past(!cur_ctl.ce_n && !cur_ctl.oe_n && cur_ctl.we_n));

    p_standby_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (standby && !$past(rst)) |-> !$past(eng_busy));

    p_psave_no_read_r6: assert property (@(posedge clk) disable iff (rst)
        pwr_save |-> !(arr_req && !arr_we));

    p_read_full_word_r3: assert property (@(posedge clk) disable iff (rst)
        (arr_req && !arr_we) |-> (arr_be == 2'b11));

    p_write_be_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
        (arr_req && arr_we) |-> (arr_be != 2'b00));

    p_write_low_half_r9: assert property (@(posedge clk) disable iff (rst)
        (arr_req && arr_we && arr_be == 2'b01) |-> (arr_wdata[15:8] == 8'h00));

    p_write_high_half_r9: assert property (@(posedge clk) disable iff (rst)
        (arr_req && arr_we && arr_be == 2'b10) |-> (arr_wdata[7:0] == 8'h00));
endmodule

bind hbi_bus_if hbi_bus_if_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .cur_ctl    (cur_ctl),
    .eng_busy   (eng_busy),
    .lane_lo_oe (lane_lo_oe),
    .lane_hi_oe (lane_hi_oe),
    .arr_req    (arr_req),
    .arr_we     (arr_we),
    .arr_be     (arr_be),
    .arr_wdata  (arr_wdata),
    .standby    (standby),
    .pwr_save   (pwr_save)
);

// File: tb/test_hbi_bus_if.sv
module test_hbi_bus_if;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_ce_n = 1'b1, host_oe_n = 1'b1, host_we_n = 1'b1, host_byte_n = 1'b1;
    logic [AW-1:0] host_addr = '0;
    logic [15:0]   host_wdata = '0;
    logic [15:0]   host_rdata;
    logic          lane_lo_oe, lane_hi_oe;
    logic          arr_req, arr_we;
    logic [AW-2:0] arr_addr;
    logic [15:0]   arr_wdata;
    logic [1:0]    arr_be;
    logic          arr_rvalid = 1'b0;
    logic [15:0]   arr_rdata = '0;
    logic          eng_busy = 1'b0;
    logic          standby, pwr_save;

    int n_cmp = 0;
    int n_bad = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [1:0]    last_be;
    logic [15:0]   last_wdata;
    logic [AW-2:0] last_addr;
    logic [15:0]   amem [16];
    bit            done = 1'b0;

    always #4 clk = ~clk;

    hbi_bus_if #(.ADDR_W(AW)) i_hbi_bus_if (
        .clk(clk), .rst(rst),
        .host_ce_n(host_ce_n), .host_oe_n(host_oe_n), .host_we_n(host_we_n),
        .host_byte_n(host_byte_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .lane_lo_oe(lane_lo_oe), .lane_hi_oe(lane_hi_oe),
        .arr_req(arr_req), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .arr_be(arr_be), .arr_rvalid(arr_rvalid), .arr_rdata(arr_rdata),
        .eng_busy(eng_busy), .standby(standby), .pwr_save(pwr_save)
    );

    function automatic logic [15:0] init_word(input int i);
        logic [3:0] n;
        n = 4'(i);
        return {4'hC, n, 4'h5, n};
    endfunction

    // Array model: one-cycle read latency, byte-enabled writes.
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) amem[i] <= init_word(i);
            arr_rvalid <= 1'b0;
        end else begin
            arr_rvalid <= arr_req && !arr_we;
            arr_rdata  <= amem[arr_addr[3:0]];
            if (arr_req && arr_we) begin
                if (arr_be[0]) amem[arr_addr[3:0]][7:0]  <= arr_wdata[7:0];
                if (arr_be[1]) amem[arr_addr[3:0]][15:8] <= arr_wdata[15:8];
                wr_cnt     <= wr_cnt + 1;
                last_be    <= arr_be;
                last_wdata <= arr_wdata;
                last_addr  <= arr_addr;
            end
            if (arr_req && !arr_we) rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_read(input logic bmode, input logic [AW-1:0] a);
        @(negedge clk);
        host_ce_n = 1'b0; host_we_n = 1'b1; host_oe_n = 1'b0;
        host_byte_n = bmode; host_addr = a;
        repeat (10) @(negedge clk);
    endtask

    task automatic do_write(input logic bmode, input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        host_oe_n = 1'b1; host_ce_n = 1'b0;
        host_byte_n = bmode; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we_n = 1'b0;
        repeat (4) @(negedge clk);
        host_we_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    // {fetch expected, width mode pin, address, expected host_rdata}
    localparam logic [25:0] VEC [9] = '{
        {1'b1, 1'b1, 8'h06, 16'hC353},
        {1'b0, 1'b1, 8'h07, 16'hC353},
        {1'b1, 1'b0, 8'h06, 16'h0053},
        {1'b1, 1'b0, 8'h07, 16'h00C3},
        {1'b1, 1'b1, 8'h0A, 16'hC555},
        {1'b1, 1'b0, 8'h0B, 16'h00C5},
        {1'b1, 1'b0, 8'h14, 16'h005A},
        {1'b1, 1'b1, 8'h1F, 16'hCF5F},
        {1'b0, 1'b1, 8'h1E, 16'hCF5F}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int r0, w0;
        // R11: reset state
        repeat (4) @(negedge clk);
        chk("R11", "arr_req in reset", 32'(arr_req), 32'd0);
        chk("R11", "pwr_save in reset", 32'(pwr_save), 32'd0);
        chk("R11", "lanes in reset", {30'd0, lane_hi_oe, lane_lo_oe}, 32'd0);
        chk("R11", "standby in reset", 32'(standby), 32'd1);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        chk("R11", "pwr_save after reset", 32'(pwr_save), 32'd0);
        chk("R11", "standby after reset", 32'(standby), 32'd1);
        chk("R11", "no request after reset", 32'(rd_cnt + wr_cnt), 32'd0);

        // Table walk: R1, R2, R3, R6
        for (int v = 0; v < 9; v++) begin
            logic        fetch, bmode;
            logic [7:0]  a;
            logic [15:0] exp;
            string       tag;
            {fetch, bmode, a, exp} = VEC[v];
            tag = bmode ? "R3" : "R1";
            r0 = rd_cnt;
            do_read(bmode, a);
            chk(tag, $sformatf("rdata vec %0d", v), 32'(host_rdata), 32'(exp));
            chk("R2", $sformatf("hi lane vec %0d", v), 32'(lane_hi_oe), 32'(bmode));
            chk("R4", $sformatf("lo lane vec %0d", v), 32'(lane_lo_oe), 32'd1);
            chk("R6", $sformatf("pwr_save vec %0d", v), 32'(pwr_save), 32'd1);
            chk("R6", $sformatf("fetch count vec %0d", v), 32'(rd_cnt - r0), 32'(fetch));
        end

        // R6: toggling output-enable with the same key does not refetch
        r0 = rd_cnt;
        host_oe_n = 1'b1; repeat (6) @(negedge clk);
        host_oe_n = 1'b0; repeat (8) @(negedge clk);
        chk("R6", "no refetch on oe toggle", 32'(rd_cnt - r0), 32'd0);
        chk("R6", "pwr_save held", 32'(pwr_save), 32'd1);

        // R7: address change with output-enable high clears flag, no fetch
        host_oe_n = 1'b1; repeat (6) @(negedge clk);
        chk("R7", "pwr_save kept same key", 32'(pwr_save), 32'd1);
        host_addr = 8'h20; repeat (6) @(negedge clk);
        chk("R7", "pwr_save cleared on address change", 32'(pwr_save), 32'd0);
        chk("R7", "no fetch while oe high", 32'(rd_cnt - r0), 32'd0);

        // R7: byte-select change in 8-bit mode
        do_read(1'b0, 8'h22);
        chk("R1", "byte low word1", 32'(host_rdata), 32'h0051);
        host_oe_n = 1'b1; host_addr = 8'h23; repeat (6) @(negedge clk);
        chk("R7", "pwr_save cleared on a0 change", 32'(pwr_save), 32'd0);

        // R8: width change clears flag
        do_read(1'b1, 8'h22);
        chk("R8", "pwr_save before width change", 32'(pwr_save), 32'd1);
        r0 = rd_cnt;
        host_oe_n = 1'b1; host_byte_n = 1'b0; repeat (6) @(negedge clk);
        chk("R8", "pwr_save cleared on width change", 32'(pwr_save), 32'd0);
        host_oe_n = 1'b0; repeat (10) @(negedge clk);
        chk("R8", "refetch after width change", 32'(rd_cnt - r0), 32'd1);
        chk("R8", "byte data after width change", 32'(host_rdata), 32'h0051);

        // R4: lane enables need both strobes low and write strobe high
        host_oe_n = 1'b1; repeat (5) @(negedge clk);
        chk("R4", "lanes off oe high", {30'd0, lane_hi_oe, lane_lo_oe}, 32'd0);
        host_ce_n = 1'b1; host_oe_n = 1'b0; repeat (5) @(negedge clk);
        chk("R4", "lanes off ce high", {30'd0, lane_hi_oe, lane_lo_oe}, 32'd0);

        // R5: standby and engine busy
        chk("R5", "standby ce high idle", 32'(standby), 32'd1);
        eng_busy = 1'b1; repeat (2) @(negedge clk);
        chk("R5", "standby held low while busy", 32'(standby), 32'd0);
        eng_busy = 1'b0; repeat (2) @(negedge clk);
        chk("R5", "standby after busy ends", 32'(standby), 32'd1);
        host_ce_n = 1'b0; host_oe_n = 1'b1; repeat (5) @(negedge clk);
        chk("R5", "standby low when selected", 32'(standby), 32'd0);

        // R10: write clears power save and forces a refetch
        do_read(1'b1, 8'h0C);
        chk("R3", "word6 initial", 32'(host_rdata), 32'hC656);
        w0 = wr_cnt;
        do_write(1'b1, 8'h0C, 16'h1234);
        chk("R10", "one write request", 32'(wr_cnt - w0), 32'd1);
        chk("R10", "pwr_save cleared by write", 32'(pwr_save), 32'd0);
        chk("R9", "word write be", 32'(last_be), 32'h3);
        chk("R9", "word write data", 32'(last_wdata), 32'h1234);
        chk("R3", "word write address", 32'(last_addr), 32'd6);

        // R9: byte writes, upper host data ignored
        do_write(1'b0, 8'h09, 16'hFF7E);
        chk("R9", "high byte be", 32'(last_be), 32'h2);
        chk("R9", "high byte data", 32'(last_wdata), 32'h7E00);
        chk("R9", "high byte address", 32'(last_addr), 32'd4);
        do_write(1'b0, 8'h0C, 16'h55AB);
        chk("R9", "low byte be", 32'(last_be), 32'h1);
        chk("R9", "low byte data", 32'(last_wdata), 32'h00AB);
        chk("R10", "write count", 32'(wr_cnt - w0), 32'd3);

        r0 = rd_cnt;
        do_read(1'b1, 8'h0C);
        chk("R10", "refetch after write", 32'(rd_cnt - r0), 32'd1);
        chk("R9", "merged word6", 32'(host_rdata), 32'h12AB);
        do_read(1'b1, 8'h08);
        chk("R9", "merged word4", 32'(host_rdata), 32'h7E54);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule